// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block carries out the hardware part of taking and leaving an interrupt on a small 8-bit core whose program counter is 10 bits wide. The arbiter outside the block presents an accepted request together with a vector index. The sequencer waits for the instruction in flight to finish. It then spends four cycles storing the two-byte return address on a stack that grows toward lower addresses, and loads the vector address into the program counter. A request that arrives while the core sleeps costs four extra wake cycles before the store.

On a return request the sequencer reads the two saved bytes back in four cycles. It restores the program counter and asks the core to set its global interrupt enable. While a sequence runs it raises `busy` so the core does not fetch. The last cycle of every sequence carries a one-cycle `done` pulse. The block drives a byte-wide data-memory port and one-step stack pointer commands. The stack pointer register itself lives outside the block. The block does not save or restore the status register.

Top module: `isr_seq_top`

## Requirements
- R1: An interrupt request taken in a cycle where `instr_done` is high makes `busy` high for exactly the next four cycles. In the fourth of those cycles `done` and `pc_load` are high together.
- R2: Entry writes the low return-address byte `pc_in[7:0]` at address `sp_in` in the first busy cycle. It writes the high byte (`pc_in[9:8]` zero-extended to 8 bits) at `sp_in-1` in the second busy cycle. Each write comes with one `sp_dec` pulse, so the stack pointer ends two lower.
- R3: The loaded vector address is `vec_idx * VEC_SPACING`, truncated to 10 bits, with a default spacing of one word.
- R4: A request taken while `instr_done` is low waits with `busy` low until `instr_done` is high. The four entry cycles start in the cycle after that.
- R5: A request taken while `sleeping` is high adds four wake cycles, also flagged by `busy`. `done` then comes eight cycles after the request.
- R6: A return request reads address `sp_in+1` (the high byte) and then `sp_in+2` (the low byte), each with one `sp_inc` pulse. Memory returns read data one cycle after `mem_re`. In the fourth cycle `done`, `pc_load` and `gie_set` are high, and `pc_load_val` is the restored 10-bit address.
- R7: `irq_req` and `ret_req` are ignored while a sequence runs. Each request gives exactly one `done` and one stack adjustment.
- R8: When `irq_req` and `ret_req` arrive in the same idle cycle, the return is carried out and the interrupt request is dropped.
- R9: Synchronous reset, including reset in the middle of a sequence, returns the block to idle. All outputs (`busy`, `done`, `pc_load`, `gie_set`, memory strobes, stack strobes) are then low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 1 | Accepted interrupt request, one cycle |
| vec_idx | input | 5 | Vector index of the accepted interrupt |
| ret_req | input | 1 | Return-from-interrupt request, one cycle |
| instr_done | input | 1 | Instruction in flight completes this cycle |
| sleeping | input | 1 | Core is in sleep mode |
| pc_in | input | 10 | Return address to save |
| sp_in | input | 16 | Current stack pointer |
| mem_rdata | input | 8 | Data memory read data, one cycle after `mem_re` |
| busy | output | 1 | Sequence running; hold off instruction fetch |
| done | output | 1 | Final cycle of a sequence |
| pc_load | output | 1 | Load `pc_load_val` into the program counter |
| pc_load_val | output | 10 | Vector or restored return address |
| gie_set | output | 1 | Set the global interrupt enable |
| mem_we | output | 1 | Data memory write strobe |
| mem_re | output | 1 | Data memory read strobe |
| mem_addr | output | 16 | Data memory address |
| mem_wdata | output | 8 | Data memory write data |
| sp_dec | output | 1 | Decrement stack pointer by one |
| sp_inc | output | 1 | Increment stack pointer by one |

## Verification
A wrong state in the sequencer shows up quickly. The ports show an off-by-one `done` cycle, or a busy window of the wrong length, within the four- or eight-cycle sequence that went wrong. A bad captured stack base or byte order leaves wrong bytes in memory and a stack pointer that is not moved by exactly two. It then shows up as a wrong restored address one full round trip later. An accepted request that is not ignored shows a second `done` or an extra stack step within a few cycles of the first.

// File: rtl/isr_seq_pkg.sv
package isr_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_WAIT,
        S_WAKE,
        S_PUSH_LO,
        S_PUSH_HI,
        S_ENT_GAP,
        S_ENT_VEC,
        S_POP_HI,
        S_POP_LO,
        S_RET_CAP,
        S_RET_END
    } seq_state_e;

    typedef struct packed {
        logic we;
        logic re;
        logic dec;
        logic inc;
    } stk_strobe_t;

    // signed offset of the memory access from the captured stack base
    function automatic logic signed [2:0] stk_offset(input seq_state_e st);
        case (st)
            S_PUSH_LO: return 3'sd0;
            S_PUSH_HI: return -3'sd1;
            S_POP_HI:  return 3'sd1;
            S_POP_LO:  return 3'sd2;
            default:   return 3'sd0;
        endcase
    endfunction

    function automatic stk_strobe_t stk_strobes(input seq_state_e st);
        stk_strobe_t s;
        s = '0;
        case (st)
            S_PUSH_LO, S_PUSH_HI: begin s.we = 1'b1; s.dec = 1'b1; end
            S_POP_HI,  S_POP_LO:  begin s.re = 1'b1; s.inc = 1'b1; end
            default: ;
        endcase
        return s;
    endfunction

    function automatic logic [31:0] vec_word(input logic [31:0] idx,
                                             input logic [31:0] spacing);
        return idx * spacing;
    endfunction

    function automatic logic seq_active(input seq_state_e st);
        return (st != S_IDLE) && (st != S_WAIT);
    endfunction

endpackage

// File: rtl/isr_seq_fsm.sv
module isr_seq_fsm
    import isr_seq_pkg::*;
#(
    parameter int WAKE_CYC = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       irq_req,
    input  logic       ret_req,
    input  logic       instr_done,
    input  logic       sleeping,
    output seq_state_e state,
    output logic       start_entry,
    output logic       start_return,
    output logic       accept_irq
);
    localparam bit HAS_WAKE = (WAKE_CYC > 0);
    localparam int CW       = (WAKE_CYC > 1) ? $clog2(WAKE_CYC) : 1;
    localparam logic [CW-1:0] WAKE_LAST = CW'(WAKE_CYC - 1);

    seq_state_e     st_q, st_d;
    logic [CW-1:0]  wake_cnt;

    always_comb begin
        st_d = st_q;
        case (st_q)
            S_IDLE: begin
                if (ret_req)
                    st_d = S_POP_HI;
                else if (irq_req) begin
                    if (sleeping && HAS_WAKE) st_d = S_WAKE;
                    else if (instr_done)      st_d = S_PUSH_LO;
                    else                      st_d = S_WAIT;
                end
            end
            S_WAIT:    if (instr_done) st_d = S_PUSH_LO;
            S_WAKE:    if (wake_cnt == WAKE_LAST) st_d = S_PUSH_LO;
            S_PUSH_LO: st_d = S_PUSH_HI;
            S_PUSH_HI: st_d = S_ENT_GAP;
            S_ENT_GAP: st_d = S_ENT_VEC;
            S_ENT_VEC: st_d = S_IDLE;
            S_POP_HI:  st_d = S_POP_LO;
            S_POP_LO:  st_d = S_RET_CAP;
            S_RET_CAP: st_d = S_RET_END;
            S_RET_END: st_d = S_IDLE;
            default:   st_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= S_IDLE;
        else     st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (rst || st_q != S_WAKE) wake_cnt <= '0;
        else                       wake_cnt <= wake_cnt + 1'b1;
    end

    assign state        = st_q;
    assign start_entry  = (st_d == S_PUSH_LO);
    assign start_return = (st_q == S_IDLE) && ret_req;
    assign accept_irq   = (st_q == S_IDLE) && irq_req && !ret_req;

endmodule

// File: rtl/isr_seq_stack.sv
module isr_seq_stack
    import isr_seq_pkg::*;
#(
    parameter int PC_W = 10,
    parameter int SP_W = 16,
    parameter int DW   = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  seq_state_e      state,
    input  logic            start_entry,
    input  logic            start_return,
    input  logic [SP_W-1:0] sp_in,
    input  logic [PC_W-1:0] pc_in,
    output logic            mem_we,
    output logic            mem_re,
    output logic [SP_W-1:0] mem_addr,
    output logic [DW-1:0]   mem_wdata,
    output logic            sp_dec,
    output logic            sp_inc
);
    localparam int EXT_W = 2 * DW;

    logic [SP_W-1:0]  base_q;
    logic [PC_W-1:0]  pc_save_q;
    logic [EXT_W-1:0] pc_ext;
    stk_strobe_t      strb;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q    <= '0;
            pc_save_q <= '0;
        end else begin
            if (start_entry || start_return) base_q <= sp_in;
            if (start_entry)                 pc_save_q <= pc_in;
        end
    end

    assign pc_ext = EXT_W'(pc_save_q);
    assign strb   = stk_strobes(state);

    always_comb begin
        mem_addr  = base_q + SP_W'(stk_offset(state));
        mem_wdata = (state == S_PUSH_HI) ? pc_ext[DW +: DW] : pc_ext[0 +: DW];
    end

    assign mem_we = strb.we;
    assign mem_re = strb.re;
    assign sp_dec = strb.dec;
    assign sp_inc = strb.inc;

endmodule

// File: rtl/isr_seq_pcgen.sv
module isr_seq_pcgen
    import isr_seq_pkg::*;
#(
    parameter int PC_W        = 10,
    parameter int VEC_W       = 5,
    parameter int VEC_SPACING = 1,
    parameter int DW          = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  seq_state_e       state,
    input  logic             accept_irq,
    input  logic [VEC_W-1:0] vec_idx,
    input  logic [DW-1:0]    mem_rdata,
    output logic             pc_load,
    output logic [PC_W-1:0]  pc_load_val,
    output logic             gie_set,
    output logic             done
);
    logic [VEC_W-1:0] idx_q;
    logic [DW-1:0]    hi_q, lo_q;
    logic [PC_W-1:0]  vec_pc, ret_pc;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
            hi_q  <= '0;
            lo_q  <= '0;
        end else begin
            if (accept_irq)           idx_q <= vec_idx;
            // read data lags the read strobe by one cycle
            if (state == S_POP_LO)    hi_q  <= mem_rdata;
            if (state == S_RET_CAP)   lo_q  <= mem_rdata;
        end
    end

    assign vec_pc = PC_W'(vec_word(32'(idx_q), 32'(VEC_SPACING)));
    assign ret_pc = PC_W'({hi_q, lo_q});

    assign done        = (state == S_ENT_VEC) || (state == S_RET_END);
    assign pc_load     = done;
    assign gie_set     = (state == S_RET_END);
    assign pc_load_val = gie_set ? ret_pc : vec_pc;

endmodule

// File: rtl/isr_seq_top.sv
module isr_seq_top
    import isr_seq_pkg::*;
#(
    parameter int PC_W        = 10,
    parameter int SP_W        = 16,
    parameter int VEC_W       = 5,
    parameter int VEC_SPACING = 1,
    parameter int WAKE_CYC    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             irq_req,
    input  logic [VEC_W-1:0] vec_idx,
    input  logic             ret_req,
    input  logic             instr_done,
    input  logic             sleeping,
    input  logic [PC_W-1:0]  pc_in,
    input  logic [SP_W-1:0]  sp_in,
    input  logic [7:0]       mem_rdata,
    output logic             busy,
    output logic             done,
    output logic             pc_load,
    output logic [PC_W-1:0]  pc_load_val,
    output logic             gie_set,
    output logic             mem_we,
    output logic             mem_re,
    output logic [SP_W-1:0]  mem_addr,
    output logic [7:0]       mem_wdata,
    output logic             sp_dec,
    output logic             sp_inc
);
    localparam int DW = 8;

    seq_state_e state;
    logic       start_entry, start_return, accept_irq;

    isr_seq_fsm #(.WAKE_CYC(WAKE_CYC)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .irq_req      (irq_req),
        .ret_req      (ret_req),
        .instr_done   (instr_done),
        .sleeping     (sleeping),
        .state        (state),
        .start_entry  (start_entry),
        .start_return (start_return),
        .accept_irq   (accept_irq)
    );

    isr_seq_stack #(.PC_W(PC_W), .SP_W(SP_W), .DW(DW)) u_stack (
        .clk          (clk),
        .rst          (rst),
        .state        (state),
        .start_entry  (start_entry),
        .start_return (start_return),
        .sp_in        (sp_in),
        .pc_in        (pc_in),
        .mem_we       (mem_we),
        .mem_re       (mem_re),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .sp_dec       (sp_dec),
        .sp_inc       (sp_inc)
    );

    isr_seq_pcgen #(.PC_W(PC_W), .VEC_W(VEC_W), .VEC_SPACING(VEC_SPACING), .DW(DW)) u_pcgen (
        .clk          (clk),
        .rst          (rst),
        .state        (state),
        .accept_irq   (accept_irq),
        .vec_idx      (vec_idx),
        .mem_rdata    (mem_rdata),
        .pc_load      (pc_load),
        .pc_load_val  (pc_load_val),
        .gie_set      (gie_set),
        .done         (done)
    );

    assign busy = seq_active(state);

endmodule

// File: rtl/isr_seq_chk.sv
module isr_seq_chk #(
    parameter int SP_W = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            busy,
    input logic            done,
    input logic            pc_load,
    input logic            gie_set,
    input logic            mem_we,
    input logic            mem_re,
    input logic [SP_W-1:0] mem_addr,
    input logic            sp_dec,
    input logic            sp_inc
);
    // R1: the program counter is only loaded in the final busy cycle
    a_r1_load_in_seq: assert property (@(posedge clk) disable iff (rst)
        pc_load |-> (busy && done));

    // R2: the two pushes are back to back, one address lower, each stepping SP down
    a_r2_push_adjacent: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we) |=> (mem_we && sp_dec && mem_addr == $past(mem_addr) - 1'b1));

    // R2: stack steps never conflict, and a write never overlaps a read
    a_r2_strobe_excl: assert property (@(posedge clk) disable iff (rst)
        !(sp_dec && sp_inc) && !(mem_we && mem_re));

    // R6: the two pops are back to back, one address higher, each stepping SP up
    a_r6_pop_adjacent: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_re) |=> (mem_re && sp_inc && mem_addr == $past(mem_addr) + 1'b1));

    // R6: enable is requested only together with the restored load
    a_r6_gie_final: assert property (@(posedge clk) disable iff (rst)
        gie_set |-> (pc_load && done));

    // R7: one completion per sequence
    a_r7_single_done: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: memory is only touched inside a running sequence
    a_r7_mem_in_seq: assert property (@(posedge clk) disable iff (rst)
        (mem_we || mem_re) |-> busy);

    // R9: reset leaves the block idle
    a_r9_reset_idle: assert property (@(posedge clk)
        rst |=> (!busy && !done && !mem_we && !mem_re));

endmodule

bind isr_seq_top isr_seq_chk #(.SP_W(SP_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .done     (done),
    .pc_load  (pc_load),
    .gie_set  (gie_set),
    .mem_we   (mem_we),
    .mem_re   (mem_re),
    .mem_addr (mem_addr),
    .sp_dec   (sp_dec),
    .sp_inc   (sp_inc)
);

// File: tb/tb_isr_seq_top.sv
module tb_isr_seq_top;
    localparam int CLK_PERIOD = 10;
    localparam int SPACING    = 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        irq_req = 1'b0, ret_req = 1'b0, instr_done = 1'b1, sleeping = 1'b0;
    logic [4:0]  vec_idx = '0;
    logic [9:0]  pc_in = '0;
    logic [15:0] sp_model = 16'h0000;
    logic [7:0]  mem_rdata;
    logic        busy, done, pc_load, gie_set, mem_we, mem_re, sp_dec, sp_inc;
    logic [9:0]  pc_load_val;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;

    logic [7:0]  mem [256];
    logic        poke_en = 1'b0;
    logic [7:0]  poke_addr = '0, poke_val = '0;
    logic        sp_set_en = 1'b0;
    logic [15:0] sp_set_val = '0;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    isr_seq_top dut (
        .clk(clk), .rst(rst), .irq_req(irq_req), .vec_idx(vec_idx), .ret_req(ret_req),
        .instr_done(instr_done), .sleeping(sleeping), .pc_in(pc_in), .sp_in(sp_model),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .pc_load(pc_load),
        .pc_load_val(pc_load_val), .gie_set(gie_set), .mem_we(mem_we), .mem_re(mem_re),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .sp_dec(sp_dec), .sp_inc(sp_inc)
    );

    // memory and stack pointer model
    always @(posedge clk) begin
        if (poke_en) mem[poke_addr] <= poke_val;
        else if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
        if (sp_set_en)   sp_model <= sp_set_val;
        else if (sp_dec) sp_model <= sp_model - 16'd1;
        else if (sp_inc) sp_model <= sp_model + 16'd1;
    end

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic poke(input logic [7:0] a, input logic [7:0] v);
        poke_en = 1'b1; poke_addr = a; poke_val = v;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    task automatic set_sp(input logic [15:0] v);
        sp_set_en = 1'b1; sp_set_val = v;
        @(negedge clk);
        sp_set_en = 1'b0;
    endtask

    // one sequence; called and returns at a negedge
    task automatic run_seq(input string tag, input logic is_ret, input logic slp,
                           input int waitn, input logic [4:0] idx, input logic [9:0] pc,
                           input logic [15:0] sp0, input logic preset, input logic both,
                           input logic spam);
        int done_k = 0, busy_n = 0, done_n = 0;
        logic [9:0] got_pc = '0;
        logic got_gie = 1'b0;
        int exp_k, exp_busy;
        logic [9:0] exp_pc;
        set_sp(sp0);
        if (is_ret && preset) begin
            poke(sp0[7:0] + 8'd1, {6'b0, pc[9:8]});
            poke(sp0[7:0] + 8'd2, pc[7:0]);
        end
        sleeping = slp; vec_idx = idx; pc_in = pc; instr_done = (waitn == 0);
        irq_req = !is_ret || both; ret_req = is_ret;
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            irq_req = spam && k <= 3;
            ret_req = spam && k <= 3;
            instr_done = (k >= waitn);
            if (busy) busy_n++;
            if (done) begin
                done_n++;
                if (done_k == 0) begin done_k = k; got_pc = pc_load_val; got_gie = gie_set; end
            end
        end
        sleeping = 1'b0; instr_done = 1'b1;
        exp_k    = is_ret ? 4 : (slp ? 8 : waitn + 4);
        exp_busy = (!is_ret && slp) ? 8 : 4;
        exp_pc   = is_ret ? pc : 10'(32'(idx) * SPACING);
        chk(tag, "done cycle", done_k, exp_k);
        chk(tag, "busy cycles", busy_n, exp_busy);
        chk(tag, "done count", done_n, 1);
        chk(tag, "loaded pc", got_pc, exp_pc);
        chk(tag, "gie_set", got_gie, is_ret);
        chk(tag, "final sp", sp_model, is_ret ? sp0 + 16'd2 : sp0 - 16'd2);
        if (!is_ret) begin
            chk(tag, "low byte at sp", mem[sp0[7:0]], pc[7:0]);
            chk(tag, "high byte at sp-1", mem[sp0[7:0] - 8'd1], {6'b0, pc[9:8]});
        end
    endtask

    typedef struct packed {
        logic        is_ret;
        logic        slp;
        logic [3:0]  waitn;
        logic [4:0]  idx;
        logic [9:0]  pc;
        logic [15:0] sp;
    } row_t;

    localparam row_t ROWS [6] = '{
        '{1'b0, 1'b0, 4'd0, 5'd3,  10'h155, 16'h00DF},
        '{1'b0, 1'b0, 4'd3, 5'd0,  10'h3FF, 16'h0100},
        '{1'b0, 1'b1, 4'd0, 5'd31, 10'h200, 16'h0080},
        '{1'b1, 1'b0, 4'd0, 5'd0,  10'h2A7, 16'h00D0},
        '{1'b1, 1'b0, 4'd0, 5'd0,  10'h001, 16'h00FD},
        '{1'b0, 1'b0, 4'd1, 5'd17, 10'h0C3, 16'h0061}
    };

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9: idle after reset
        chk("R9", "busy", busy, 0);
        chk("R9", "done", done, 0);
        chk("R9", "strobes", {mem_we, mem_re, sp_dec, sp_inc, pc_load, gie_set}, 0);

        // table: R1 R2 R3 R4 R5 R6
        for (int r = 0; r < 6; r++)
            run_seq("R1/R2/R3/R4/R5/R6", ROWS[r].is_ret, ROWS[r].slp, int'(ROWS[r].waitn),
                    ROWS[r].idx, ROWS[r].pc, ROWS[r].sp, 1'b1, 1'b0, 1'b0);

        // R6 round trip: entry then return restores the saved address
        run_seq("R2", 1'b0, 1'b0, 0, 5'd5, 10'h1E4, 16'h0090, 1'b0, 1'b0, 1'b0);
        run_seq("R6", 1'b1, 1'b0, 0, 5'd0, 10'h1E4, 16'h008E, 1'b0, 1'b0, 1'b0);
        chk("R6", "round trip sp", sp_model, 16'h0090);

        // R7: requests during a running return are ignored
        run_seq("R7", 1'b1, 1'b0, 0, 5'd9, 10'h0F0, 16'h0040, 1'b1, 1'b0, 1'b1);

        // R8: simultaneous requests, return wins
        run_seq("R8", 1'b1, 1'b0, 0, 5'd9, 10'h3C5, 16'h0050, 1'b1, 1'b1, 1'b0);

        // R9: reset in the middle of an entry
        set_sp(16'h0070);
        pc_in = 10'h123; vec_idx = 5'd2; irq_req = 1'b1;
        @(negedge clk);
        irq_req = 1'b0;
        chk("R9", "busy mid-entry", busy, 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R9", "busy after reset", busy, 0);
        chk("R9", "strobes after reset", {mem_we, sp_dec, done}, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule